// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a byte-wide SPI master that sits on a small synchronous register bus. Software configures it through a control register and a status/control register, then starts a transfer by writing a byte to the data address. The byte is shifted out MSB first on MOSI while a byte is shifted in from MISO on the same SCK edges. Clock polarity, clock phase and one of four serial clock rates are selectable.

Transmit data is buffered one byte ahead of the shift engine. A write made while a byte is still shifting waits in the buffer and starts as soon as the current byte ends. The received byte lands in its own receive register. A transmitter-empty flag and a receiver-full flag drive two interrupt request lines. The receiver-full flag is released by a two-step read: status first, then data. Bits that belong to slave operation, fault detection and open-drain pin drive are storage only and have no effect.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control address (0) reads 0x28, the status address (1) reads 0x08, SCK is low, and both interrupt lines are low.
- R2: Control bits, MSB first: receive-interrupt enable, constant 0, master, polarity, phase, open-drain select (held only), enable, transmit-interrupt enable. Status bits, MSB first: receiver full, error-interrupt enable (held only), overrun, mode fault (reads 0), transmitter empty, fault enable (held only), baud code [1:0]. Writing 0xFF to control reads back 0xBF, and writing 0xFF to status reads back 0x4F while idle.
- R3: A write to the data address (2) makes transmitter empty (status bit 3) read 0 in the cycle after the write. If the engine is idle, enabled and in master mode, the byte enters the shifter on the next edge and transmitter empty reads 1 again from the second cycle after the write.
- R4: No transfer starts unless both enable and master are set. A byte written otherwise waits with transmitter empty at 0 and no SCK edges, and it is sent once both bits are set.
- R5: A transfer makes exactly 16 SCK edges and exchanges one byte in each direction, MSB first, in full duplex.
- R6: With the engine idle, SCK equals the polarity bit. With phase 0, a bit is valid before the leading edge, is sampled on the leading edge and changes on the trailing edge. With phase 1, a bit changes on the leading edge and is sampled on the trailing edge.
- R7: Baud codes 00, 01, 10 and 11 divide the module clock by 2, 8, 32 and 128, so consecutive SCK edges are 1, 4, 16 and 64 cycles apart.
- R8: A data write during a transfer holds the byte in the buffer with transmitter empty at 0 until the current byte ends. The held byte then starts automatically and transmitter empty returns to 1.
- R9: Receiver full (status bit 7) sets in the same cycle that the received byte is stored. It clears only on a data read that follows a status read taken while the flag was set. A data read alone leaves it set.
- R10: A transfer that ends while receiver full is set sets overrun (status bit 5) and leaves the receive register unchanged. Overrun clears on a status read taken while it is set, followed by a data read.
- R11: The transmit interrupt line equals transmit-interrupt enable AND transmitter empty. The receive interrupt line equals receive-interrupt enable AND receiver full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status/control, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_tx | output | 1 | Transmitter-empty interrupt request |
| irq_rx | output | 1 | Receiver-full interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: an 8-bit shift engine and a 7-bit half-period counter. At these values all four baud codes can be reached, including the slowest one, which spends 64 cycles per SCK half-period and 1024 cycles per byte. That slow rate leaves room to write a second byte, observe the buffered state, and change the slave's reply between two chained transfers. A clocked slave model covers all four polarity and phase pairings and measures edge count and spacing.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    typedef struct packed {
        logic       rie;
        logic       mstr;
        logic       cpol;
        logic       cpha;
        logic       wom;
        logic       en;
        logic       tie;
        logic       errie;
        logic       modfen;
        logic [1:0] baud;
        logic       rxf;
        logic       ovr;
        logic       txe;
        logic       arm_rxf;
        logic       arm_ovr;
    } regs_t;

    localparam regs_t REGS_RST = '{mstr: 1'b1, cpha: 1'b1, txe: 1'b1, default: '0};

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int unsigned BITS   = 8,
    parameter int unsigned HALF_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cpha,
    input  logic [1:0]      baud,
    input  logic            load,
    input  logic [BITS-1:0] load_byte,
    input  logic            miso,
    output logic            busy,
    output logic            sck_lvl,
    output logic            mosi,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);

    localparam int unsigned EDGES = 2 * BITS;
    localparam int unsigned EW    = $clog2(EDGES);

    typedef struct packed {
        logic            busy;
        logic            lvl;
        logic            outb;
        logic            done;
        logic [HALF_W-1:0] hcnt;
        logic [EW-1:0]   ecnt;
        logic [BITS-1:0] txs;
        logic [BITS-1:0] rxs;
    } eng_t;

    eng_t q, d;
    logic [HALF_W-1:0] half;
    logic              sample_now;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        half       = HALF_W'(1) << {baud, 1'b0};
        // leading edges have an even index; phase picks which edge samples
        sample_now = (~q.ecnt[0]) ^ cpha;
        if (!enable) begin
            d.busy = 1'b0;
            d.lvl  = 1'b0;
            d.hcnt = '0;
        end else if (load && !q.busy) begin
            d.busy = 1'b1;
            d.lvl  = 1'b0;
            d.hcnt = '0;
            d.ecnt = '0;
            d.txs  = load_byte;
            d.outb = load_byte[BITS-1];
        end else if (q.busy) begin
            if (q.hcnt == half - HALF_W'(1)) begin
                d.hcnt = '0;
                d.lvl  = ~q.lvl;
                d.ecnt = q.ecnt + EW'(1);
                if (sample_now) begin
                    d.rxs = {q.rxs[BITS-2:0], miso};
                end else begin
                    if (cpha) d.outb = q.txs[BITS-1];
                    d.txs = {q.txs[BITS-2:0], 1'b0};
                end
                if (q.ecnt == EW'(EDGES - 1)) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end else begin
                d.hcnt = q.hcnt + HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sck_lvl = q.lvl;
    assign mosi    = cpha ? q.outb : q.txs[BITS-1];
    assign done    = q.done;
    assign rx_byte = q.rxs;

endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       xfer_done,
    input  logic [7:0] xfer_byte,
    input  logic       eng_busy,
    output logic       load,
    output logic [7:0] load_byte,
    output logic       ctl_en,
    output logic       ctl_mstr,
    output logic       ctl_cpol,
    output logic       ctl_cpha,
    output logic [1:0] ctl_baud,
    output logic       st_rxf,
    output logic       st_ovr,
    output logic       st_txe,
    output logic       irq_tx,
    output logic       irq_rx
);

    regs_t      q, d;
    logic [7:0] txbuf_q, txbuf_d;
    logic [7:0] rxbuf_q, rxbuf_d;
    logic       wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;

    always_comb begin
        wr_ctrl = bus_sel &&  bus_wr && bus_addr == A_CTRL;
        wr_stat = bus_sel &&  bus_wr && bus_addr == A_STAT;
        wr_data = bus_sel &&  bus_wr && bus_addr == A_DATA;
        rd_stat = bus_sel && !bus_wr && bus_addr == A_STAT;
        rd_data = bus_sel && !bus_wr && bus_addr == A_DATA;
        d       = q;
        txbuf_d = txbuf_q;
        rxbuf_d = rxbuf_q;
        load    = !q.txe && q.en && q.mstr && !eng_busy;

        if (wr_ctrl) begin
            d.rie  = bus_wdata[7];
            d.mstr = bus_wdata[5];
            d.cpol = bus_wdata[4];
            d.cpha = bus_wdata[3];
            d.wom  = bus_wdata[2];
            d.en   = bus_wdata[1];
            d.tie  = bus_wdata[0];
        end
        if (wr_stat) begin
            d.errie  = bus_wdata[6];
            d.modfen = bus_wdata[2];
            d.baud   = bus_wdata[1:0];
        end
        if (load) d.txe = 1'b1;
        if (wr_data) begin
            d.txe   = 1'b0;
            txbuf_d = bus_wdata;
        end
        if (rd_stat) begin
            d.arm_rxf = q.rxf;
            d.arm_ovr = q.ovr;
        end
        if (rd_data) begin
            if (q.arm_rxf) d.rxf = 1'b0;
            if (q.arm_ovr) d.ovr = 1'b0;
            d.arm_rxf = 1'b0;
            d.arm_ovr = 1'b0;
        end
        if (xfer_done) begin
            if (d.rxf) begin
                d.ovr = 1'b1;
            end else begin
                d.rxf   = 1'b1;
                rxbuf_d = xfer_byte;
            end
        end

        case (bus_addr)
            A_CTRL:  bus_rdata = {q.rie, 1'b0, q.mstr, q.cpol, q.cpha, q.wom, q.en, q.tie};
            A_STAT:  bus_rdata = {q.rxf, q.errie, q.ovr, 1'b0, q.txe, q.modfen, q.baud};
            A_DATA:  bus_rdata = rxbuf_q;
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    // data buffers keep their contents across reset
    always_ff @(posedge clk) begin
        txbuf_q <= txbuf_d;
        rxbuf_q <= rxbuf_d;
    end

    assign load_byte = txbuf_q;
    assign ctl_en    = q.en;
    assign ctl_mstr  = q.mstr;
    assign ctl_cpol  = q.cpol;
    assign ctl_cpha  = q.cpha;
    assign ctl_baud  = q.baud;
    assign st_rxf    = q.rxf;
    assign st_ovr    = q.ovr;
    assign st_txe    = q.txe;
    assign irq_tx    = q.tie & q.txe;
    assign irq_rx    = q.rie & q.rxf;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
    parameter int unsigned HALF_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_tx,
    output logic       irq_rx,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);

    localparam int unsigned BYTE_W = 8;

    logic              load, eng_busy, eng_done, sck_lvl;
    logic [BYTE_W-1:0] load_byte, rx_byte;
    logic              ctl_en, ctl_mstr, ctl_cpol, ctl_cpha;
    logic [1:0]        ctl_baud;
    logic              st_rxf, st_ovr, st_txe;

    spi_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .xfer_done (eng_done),
        .xfer_byte (rx_byte),
        .eng_busy  (eng_busy),
        .load      (load),
        .load_byte (load_byte),
        .ctl_en    (ctl_en),
        .ctl_mstr  (ctl_mstr),
        .ctl_cpol  (ctl_cpol),
        .ctl_cpha  (ctl_cpha),
        .ctl_baud  (ctl_baud),
        .st_rxf    (st_rxf),
        .st_ovr    (st_ovr),
        .st_txe    (st_txe),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx)
    );

    spi_shift_engine #(.BITS(BYTE_W), .HALF_W(HALF_W)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctl_en & ctl_mstr),
        .cpha      (ctl_cpha),
        .baud      (ctl_baud),
        .load      (load),
        .load_byte (load_byte),
        .miso      (miso),
        .busy      (eng_busy),
        .sck_lvl   (sck_lvl),
        .mosi      (mosi),
        .done      (eng_done),
        .rx_byte   (rx_byte)
    );

    assign sck = ctl_cpol ^ sck_lvl;

endmodule

// File: rtl/spi_master_checks.sv
module spi_master_checks (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic mstr,
    input logic cpol,
    input logic sck,
    input logic busy,
    input logic done,
    input logic rxf,
    input logic ovr,
    input logic txe,
    input logic data_rd,
    input logic data_wr
);

    a_r6_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);

    a_r9_full_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxf) |-> $past(done));

    a_r9_full_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxf) |-> $past(data_rd));

    a_r10_overrun_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(done) && $past(rxf));

    a_r3_empty_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txe) |-> $past(data_wr));

    a_r4_start_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en && mstr));

endmodule

bind spi_byte_master spi_master_checks i_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl_en),
    .mstr    (ctl_mstr),
    .cpol    (ctl_cpol),
    .sck     (sck),
    .busy    (eng_busy),
    .done    (eng_done),
    .rxf     (st_rxf),
    .ovr     (st_ovr),
    .txe     (st_txe),
    .data_rd (bus_sel && !bus_wr && bus_addr == 2'd2),
    .data_wr (bus_sel && bus_wr && bus_addr == 2'd2)
);

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_tx, irq_rx, sck, mosi;
    logic       miso = 1'b0;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    // slave model state
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, sl_prev = 1'b0, lead;
    logic [7:0] sl_tx = '0, sl_cap = '0;
    int         sl_idx = 0, sl_edges = 0, sl_first = 0, sl_last = 0;

    // {cpol, cpha, baud[1:0], master byte, slave byte}
    localparam logic [19:0] VEC [0:5] = '{
        20'h0A53C, 20'h5817E, 20'hA5AC3, 20'hCFF00, 20'h30180, 20'hD9669
    };

    spi_byte_master i_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && sck !== sl_prev) begin
            lead = (sl_prev == cfg_cpol);
            if (sl_edges == 0) sl_first = cyc;
            sl_last  = cyc;
            sl_edges = sl_edges + 1;
            if (lead ^ cfg_cpha) begin
                sl_cap = {sl_cap[6:0], mosi};
            end else if (cfg_cpha) begin
                miso   = sl_tx[7 - sl_idx];
                sl_idx = (sl_idx + 1) % 8;
            end else begin
                sl_idx = (sl_idx + 1) % 8;
                miso   = sl_tx[7 - sl_idx];
            end
        end
        sl_prev = sck;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 v = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic slave_arm(input logic pol, input logic pha, input logic [7:0] b);
        cfg_cpol = pol; cfg_cpha = pha; sl_tx = b; sl_idx = 0;
        sl_edges = 0; sl_cap = '0; sl_prev = pol;
        miso = pha ? 1'b0 : b[7];
    endtask

    task automatic wait_status(input int bitn, output logic [7:0] st);
        st = '0;
        for (int k = 0; k < 4000 && !st[bitn]; k++) bus_read(2'd1, st);
        check("poll status", 32'(st[bitn]), 32'd1);
    endtask

    initial begin
        logic [7:0]  st, r, txb, slb;
        logic [19:0] v;
        logic        pol, pha;
        logic [1:0]  bd;
        int          half;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, r);  check("R1 ctrl reset", 32'(r), 32'h28);
        bus_read(2'd1, st); check("R1 status reset", 32'(st), 32'h08);
        check("R1 sck idle", 32'(sck), 32'd0);
        check("R1 irq lines", 32'({irq_tx, irq_rx}), 32'd0);

        // R2 layout, reserved and held bits
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, r);  check("R2 ctrl readback", 32'(r), 32'hBF);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, st); check("R2 status readback", 32'(st), 32'h4F);
        check("R11 irq_tx with enable and empty", 32'(irq_tx), 32'd1);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h28);

        // R5 R6 R7 vector table
        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            pol = v[19]; pha = v[18]; bd = v[17:16]; txb = v[15:8]; slb = v[7:0];
            half = 1 << (2 * bd);
            bus_write(2'd0, {2'b00, 1'b1, pol, pha, 1'b0, 1'b1, 1'b0});
            bus_write(2'd1, {6'b0, bd});
            check("R6 idle sck equals polarity", 32'(sck), 32'(pol));
            slave_arm(pol, pha, slb);
            bus_write(2'd2, txb);
            wait_status(7, st);
            bus_read(2'd2, r);
            check("R5 master received", 32'(r), 32'(slb));
            check("R6 slave captured", 32'(sl_cap), 32'(txb));
            check("R5 edge count", 32'(sl_edges), 32'd16);
            check("R7 edge spacing", 32'(sl_last - sl_first), 32'(15 * half));
            bus_read(2'd1, st);
            check("R9 full cleared by sequence", 32'(st[7]), 32'd0);
        end

        // R4 gated by master mode
        bus_write(2'd0, 8'h02);
        bus_write(2'd1, 8'h00);
        slave_arm(1'b0, 1'b0, 8'hC6);
        bus_write(2'd2, 8'h3C);
        repeat (60) @(negedge clk);
        check("R4 no edges without master", 32'(sl_edges), 32'd0);
        bus_read(2'd1, st);
        check("R4 byte waits", 32'(st[3]), 32'd0);
        bus_write(2'd0, 8'h22);
        wait_status(7, st);
        bus_read(2'd2, r);
        check("R4 late start received", 32'(r), 32'hC6);
        check("R4 late start sent", 32'(sl_cap), 32'h3C);

        // R3 R8 R10 buffered write and overrun at slowest rate
        bus_write(2'd0, 8'h2B);
        bus_write(2'd1, 8'h03);
        slave_arm(1'b0, 1'b1, 8'hA1);
        bus_write(2'd2, 8'h96);
        check("R3 empty low after write", 32'(irq_tx), 32'd0);
        @(negedge clk);
        check("R3 empty back after load", 32'(irq_tx), 32'd1);
        bus_write(2'd2, 8'h55);
        check("R8 empty low while busy", 32'(irq_tx), 32'd0);
        repeat (200) @(negedge clk);
        check("R8 empty still low", 32'(irq_tx), 32'd0);
        wait_status(7, st);
        sl_tx = 8'h0F;
        check("R5 first byte sent", 32'(sl_cap), 32'h96);
        repeat (2) @(negedge clk);
        check("R8 buffered byte taken", 32'(irq_tx), 32'd1);
        wait_status(5, st);
        check("R10 status with overrun", 32'(st), 32'hAB);
        bus_read(2'd2, r);
        check("R10 receive register kept", 32'(r), 32'hA1);
        bus_read(2'd1, st);
        check("R10 flags cleared", 32'(st), 32'h0B);
        check("R8 second byte sent", 32'(sl_cap), 32'h55);

        // R9 R11 data read alone does not clear
        bus_write(2'd0, 8'hA2);
        bus_write(2'd1, 8'h00);
        slave_arm(1'b0, 1'b0, 8'h5E);
        bus_write(2'd2, 8'h11);
        for (int k = 0; k < 200 && !irq_rx; k++) @(negedge clk);
        check("R11 irq_rx on full", 32'(irq_rx), 32'd1);
        bus_read(2'd2, r);
        check("R9 received byte", 32'(r), 32'h5E);
        bus_read(2'd1, st);
        check("R9 data read alone keeps full", 32'(st[7]), 32'd1);
        bus_read(2'd2, r);
        bus_read(2'd1, st);
        check("R9 cleared after sequence", 32'(st[7]), 32'd0);
        check("R11 irq_rx released", 32'(irq_rx), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule